// File: doc/BRIEF.md
# Four-State Transparent RAM

This block is a small random access memory with no clock. Storage is held in level-sensitive latches, so a word follows its data input for as long as a write is enabled at its address. Four-state logic is carried in synthesizable form. Every input bit arrives as a value bit plus an "unknown" flag, and a set flag makes the bit unknown whatever the value bit says. Every output bit leaves as three flags: a value bit, a high-impedance flag and an unknown flag. An unknown enable or an unknown address bit is not treated as 0 or 1. It spreads into the stored words and onto the read port, following the rules below.

The block suits a mixed-signal or gate-level style environment that models a simple RAM cell array. There, pessimistic unknown handling must survive synthesis and equivalence checks. Reading and writing may be active together, and the read port then shows the freshly written word in the same instant. An active-low reset marks every stored bit unknown.

Top module: `xlatch_ram`

## Requirements
- R1: While the read enable is known low (`re_unk`=0, `re_val`=0), every output bit is high impedance (`dout_hiz`=1, `dout_unk`=0, `dout_val`=0), whatever the address.
- R2: While the read enable is known high and no address bit is unknown, the output shows the word stored at `addr_val`: `dout_val` and `dout_unk` equal the stored value and unknown flags, and `dout_hiz`=0.
- R3: While the read enable is known high and any `addr_unk` bit is set, every output bit is unknown (`dout_unk`=1, `dout_hiz`=0, `dout_val`=0).
- R4: While `re_unk`=1, every output bit is unknown, whatever `re_val` and the address are.
- R5: While the write enable is known low, no stored word changes.
- R6: While the write enable is known high and the address is fully known, the addressed word takes `din_unk` as its unknown flags and `din_val & ~din_unk` as its value bits.
- R7: While the write enable is known high and any address bit is unknown, no stored word changes.
- R8: While `we_unk`=1 and the address is fully known, every bit of the addressed word becomes unknown, and no other word changes.
- R9: While `we_unk`=1 and any address bit is unknown, no stored word changes.
- R10: When a write and a read are both active at the same known address, the output shows the data being written without waiting for the write enable to drop.
- R11: While `rst_n` is low, every stored bit is unknown, and it stays unknown after reset is released until that word is written.
- R12: No output bit has both `dout_unk` and `dout_hiz` set, and `dout_val` is 0 for every bit that is unknown or high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; marks all storage unknown |
| re_val | input | 1 | Read enable, value bit |
| re_unk | input | 1 | Read enable, unknown flag |
| we_val | input | 1 | Write enable, value bit |
| we_unk | input | 1 | Write enable, unknown flag |
| addr_val | input | ADDR_W | Address, value bits |
| addr_unk | input | ADDR_W | Address, unknown flags |
| din_val | input | DATA_W | Write data, value bits |
| din_unk | input | DATA_W | Write data, unknown flags |
| dout_val | output | DATA_W | Read data, value bits |
| dout_hiz | output | DATA_W | Read data, high-impedance flags |
| dout_unk | output | DATA_W | Read data, unknown flags |

## Verification
A word that captured wrongly, such as a poisoned word that is still marked known or a write that slipped past an unknown address, stays hidden until that word is read. Once the read enable is high at a known address, it shows within the same settling step. The bench therefore follows every write-class operation with a read of the whole array. Decode or read-path errors show at once on the output flags, because the read port has no state between storage and pins.

// File: rtl/xlr_pkg.sv
package xlr_pkg;

  // Resolved level of one dual-rail control bit.
  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_HI  = 2'd1,
    LVL_UNK = 2'd2
  } lvl_e;

  // The unknown flag dominates the value bit.
  function automatic lvl_e lvl_of(input logic v, input logic u);
    if (u) return LVL_UNK;
    return v ? LVL_HI : LVL_LO;
  endfunction

endpackage

// File: rtl/xlr_wr_decode.sv
module xlr_wr_decode
  import xlr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int NWORDS = 1 << ADDR_W
) (
  input  logic              we_val,
  input  logic              we_unk,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [ADDR_W-1:0] addr_unk,
  output logic [NWORDS-1:0] load_data,
  output logic [NWORDS-1:0] load_unk
);

  lvl_e we_lvl;
  logic addr_known;
  logic data_en;
  logic poison_en;

  always_comb begin
    we_lvl     = lvl_of(we_val, we_unk);
    addr_known = ~|addr_unk;
    data_en    = addr_known && (we_lvl == LVL_HI);
    poison_en  = addr_known && (we_lvl == LVL_UNK);
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_strobe
    assign load_data[w] = data_en   && (addr_val == ADDR_W'(w));
    assign load_unk[w]  = poison_en && (addr_val == ADDR_W'(w));
  end

  // R7 / R9: a write may only ever reach one word at a time
  always_comb begin
    a_r7_single_target: assert ($onehot0(load_data | load_unk))
      else $error("a_r7_single_target: more than one word strobed");
  end

endmodule

// File: rtl/xlr_word.sv
module xlr_word #(
  parameter int DATA_W = 2
) (
  input  logic              rst_n,
  input  logic              load_data,
  input  logic              load_unk,
  input  logic [DATA_W-1:0] din_val,
  input  logic [DATA_W-1:0] din_unk,
  output logic [DATA_W-1:0] q_val,
  output logic [DATA_W-1:0] q_unk
);

  logic [DATA_W-1:0] nxt_val;
  logic [DATA_W-1:0] nxt_unk;
  logic              open_en;

  // next-state
  always_comb begin
    open_en = load_data | load_unk;
    if (load_unk) begin
      nxt_val = '0;
      nxt_unk = '1;
    end else begin
      nxt_val = din_val & ~din_unk;
      nxt_unk = din_unk;
    end
  end

  // storage: transparent while a strobe is high
  always_latch begin
    if (!rst_n) begin
      q_val = '0;
      q_unk = '1;
    end else if (open_en) begin
      q_val = nxt_val;
      q_unk = nxt_unk;
    end
  end

  // R11: reset forces the word to all-unknown
  always_comb begin
    if (!rst_n) begin
      a_r11_reset_unknown: assert (&q_unk && (q_val == '0))
        else $error("a_r11_reset_unknown: word not unknown in reset");
    end
  end

endmodule

// File: rtl/xlr_rd_sel.sv
module xlr_rd_sel
  import xlr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 2,
  parameter int NWORDS = 1 << ADDR_W
) (
  input  logic                           re_val,
  input  logic                           re_unk,
  input  logic [ADDR_W-1:0]              addr_val,
  input  logic [ADDR_W-1:0]              addr_unk,
  input  logic [NWORDS-1:0][DATA_W-1:0]  word_val,
  input  logic [NWORDS-1:0][DATA_W-1:0]  word_unk,
  output logic [DATA_W-1:0]              dout_val,
  output logic [DATA_W-1:0]              dout_hiz,
  output logic [DATA_W-1:0]              dout_unk
);

  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] sel_unk;

  always_comb begin
    sel_val  = word_val[addr_val];
    sel_unk  = word_unk[addr_val];
    dout_val = '0;
    dout_hiz = '0;
    dout_unk = '1;
    unique case (lvl_of(re_val, re_unk))
      LVL_LO: begin
        dout_hiz = '1;
        dout_unk = '0;
      end
      LVL_HI: begin
        if (~|addr_unk) begin
          dout_val = sel_val;
          dout_unk = sel_unk;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xlatch_ram.sv
module xlatch_ram #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 2
) (
  input  logic              rst_n,
  input  logic              re_val,
  input  logic              re_unk,
  input  logic              we_val,
  input  logic              we_unk,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [ADDR_W-1:0] addr_unk,
  input  logic [DATA_W-1:0] din_val,
  input  logic [DATA_W-1:0] din_unk,
  output logic [DATA_W-1:0] dout_val,
  output logic [DATA_W-1:0] dout_hiz,
  output logic [DATA_W-1:0] dout_unk
);

  localparam int NWORDS = 1 << ADDR_W;

  logic [NWORDS-1:0]             load_data;
  logic [NWORDS-1:0]             load_unk;
  logic [NWORDS-1:0][DATA_W-1:0] mem_val;
  logic [NWORDS-1:0][DATA_W-1:0] mem_unk;

  xlr_wr_decode #(
    .ADDR_W (ADDR_W),
    .NWORDS (NWORDS)
  ) u_dec (
    .we_val    (we_val),
    .we_unk    (we_unk),
    .addr_val  (addr_val),
    .addr_unk  (addr_unk),
    .load_data (load_data),
    .load_unk  (load_unk)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    xlr_word #(
      .DATA_W (DATA_W)
    ) u_word (
      .rst_n     (rst_n),
      .load_data (load_data[w]),
      .load_unk  (load_unk[w]),
      .din_val   (din_val),
      .din_unk   (din_unk),
      .q_val     (mem_val[w]),
      .q_unk     (mem_unk[w])
    );
  end

  xlr_rd_sel #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NWORDS (NWORDS)
  ) u_rd (
    .re_val   (re_val),
    .re_unk   (re_unk),
    .addr_val (addr_val),
    .addr_unk (addr_unk),
    .word_val (mem_val),
    .word_unk (mem_unk),
    .dout_val (dout_val),
    .dout_hiz (dout_hiz),
    .dout_unk (dout_unk)
  );

  // port-level invariants across decode, storage and read path
  always_comb begin
    a_r12_flags_exclusive: assert (((dout_unk & dout_hiz) == '0) &&
                                   ((dout_val & (dout_unk | dout_hiz)) == '0))
      else $error("a_r12_flags_exclusive: illegal output encoding");

    if (!re_unk && !re_val) begin
      a_r1_idle_hiz: assert (&dout_hiz)
        else $error("a_r1_idle_hiz: output not high impedance");
    end

    if (re_unk) begin
      a_r4_re_unknown: assert (&dout_unk)
        else $error("a_r4_re_unknown: output not unknown");
    end

    if (|addr_unk) begin
      a_r7_addr_x_blocks: assert ((load_data | load_unk) == '0)
        else $error("a_r7_addr_x_blocks: write reached storage");
    end

    if (rst_n && re_val && !re_unk && we_val && !we_unk && (addr_unk == '0)) begin
      a_r10_write_through: assert ((dout_unk == din_unk) &&
                                   (dout_val == (din_val & ~din_unk)) &&
                                   (dout_hiz == '0))
        else $error("a_r10_write_through: read does not show written data");
    end
  end

endmodule

// File: tb/xlatch_ram_tb.sv
`timescale 1ns/1ps
module xlatch_ram_tb_top;

  localparam int AW = 3;
  localparam int DW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          re_val, re_unk, we_val, we_unk;
  logic [AW-1:0] addr_val, addr_unk;
  logic [DW-1:0] din_val, din_unk;
  logic [DW-1:0] dout_val, dout_hiz, dout_unk;

  logic [DW-1:0] mv [NW];
  logic [DW-1:0] mu [NW];

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xlatch_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .rst_n    (rst_n),
    .re_val   (re_val),
    .re_unk   (re_unk),
    .we_val   (we_val),
    .we_unk   (we_unk),
    .addr_val (addr_val),
    .addr_unk (addr_unk),
    .din_val  (din_val),
    .din_unk  (din_unk),
    .dout_val (dout_val),
    .dout_hiz (dout_hiz),
    .dout_unk (dout_unk)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic model_reset();
    for (int i = 0; i < NW; i++) begin
      mv[i] = '0;
      mu[i] = '1;
    end
  endtask

  task automatic check(input string tag);
    logic [DW-1:0] ev, eh, eu;
    ev = '0; eh = '0; eu = '1;
    if (re_unk) begin
      eu = '1;
    end else if (!re_val) begin
      eh = '1; eu = '0;
    end else if (addr_unk == '0) begin
      ev = mv[addr_val]; eu = mu[addr_val];
    end
    n_chk++;
    if (dout_val !== ev || dout_hiz !== eh || dout_unk !== eu) begin
      n_bad++;
      $display("FAIL %s: addr=%0d got v/z/x=%h/%h/%h exp %h/%h/%h",
               tag, addr_val, dout_val, dout_hiz, dout_unk, ev, eh, eu);
    end
    // R12: encoding invariant on every sample
    n_chk++;
    if ((dout_unk & dout_hiz) != '0 || (dout_val & (dout_unk | dout_hiz)) != '0) begin
      n_bad++;
      $display("FAIL R12: got v/z/x=%h/%h/%h exp disjoint flags and zero value",
               dout_val, dout_hiz, dout_unk);
    end
  endtask

  // one operation: drop write, set address/data/read, raise write, sample
  task automatic op(input logic rv, input logic ru, input logic wv, input logic wu,
                    input logic [AW-1:0] av, input logic [AW-1:0] au,
                    input logic [DW-1:0] dv, input logic [DW-1:0] du,
                    input string tag);
    @(posedge clk);
    we_val = 1'b0; we_unk = 1'b0;
    #1;
    re_val = rv; re_unk = ru;
    addr_val = av; addr_unk = au;
    din_val = dv; din_unk = du;
    #1;
    we_val = wv; we_unk = wu;
    if (rst_n && au == '0) begin
      if (!wu && wv) begin
        mv[av] = dv & ~du; mu[av] = du;
      end else if (wu) begin
        mv[av] = '0; mu[av] = '1;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < NW; a++)
      op(1'b1, 1'b0, 1'b0, 1'b0, AW'(a), '0, DW'(a * 7), '0, tag);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    re_val = 0; re_unk = 0; we_val = 0; we_unk = 0;
    addr_val = '0; addr_unk = '0; din_val = '0; din_unk = '0;
    model_reset();
    repeat (2) @(posedge clk);

    // R11 and R1 while reset is held; writes have no effect in reset
    for (int a = 0; a < NW; a++) begin
      op(1'b1, 1'b0, 1'b1, 1'b0, AW'(a), '0, 4'h5, '0, "R11");
      op(1'b0, 1'b0, 1'b0, 1'b0, AW'(a), '0, '0, '0, "R1");
    end
    @(posedge clk);
    rst_n = 1'b1;
    read_all("R11");

    // R10 / R6: write with simultaneous read at the same address
    for (int a = 0; a < NW; a++)
      op(1'b1, 1'b0, 1'b1, 1'b0, AW'(a), '0, DW'((a * 5 + 3) % 16), '0, "R10");
    read_all("R2");

    // R1: read disabled, any address, write idle
    for (int a = 0; a < NW; a++)
      op(1'b0, 1'b0, 1'b0, 1'b0, AW'(a), '0, '1, '1, "R1");

    // R5: write enable low with differing data
    for (int a = 0; a < NW; a++)
      op(1'b1, 1'b0, 1'b0, 1'b0, AW'(a), '0, ~DW'(a), '0, "R5");

    // R6: data carrying unknown flags, even addresses only
    for (int a = 0; a < NW; a += 2)
      op(1'b0, 1'b0, 1'b1, 1'b0, AW'(a), '0, 4'hF, DW'((a * 3 + 1) % 16), "R6");
    read_all("R6");

    // R7: write high with one unknown address bit
    for (int b = 0; b < AW; b++)
      op(1'b1, 1'b0, 1'b1, 1'b0, AW'(b), AW'(1 << b), 4'hA, '0, "R7");
    read_all("R7");

    // R3: read high with every non-zero unknown-address pattern
    for (int u = 1; u < NW; u++)
      op(1'b1, 1'b0, 1'b0, 1'b0, AW'(u), AW'(u), '0, '0, "R3");

    // R4: read enable unknown, value bit either way
    for (int a = 0; a < NW; a++)
      op(a[0], 1'b1, 1'b0, 1'b0, AW'(a), AW'(a & 1), '0, '0, "R4");

    // R8: write enable unknown at known addresses
    op(1'b1, 1'b0, 1'b0, 1'b1, AW'(1), '0, 4'h3, '0, "R8");
    op(1'b1, 1'b0, 1'b0, 1'b1, AW'(6), '0, 4'hC, '0, "R8");
    read_all("R8");

    // R9: write enable unknown with unknown address
    op(1'b0, 1'b0, 1'b1, 1'b1, AW'(2), AW'(2), 4'h9, '0, "R9");
    op(1'b0, 1'b0, 1'b0, 1'b1, AW'(3), AW'(4), 4'h6, '0, "R9");
    read_all("R9");

    // R11: reset mid-run clears everything back to unknown
    @(posedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    @(posedge clk);
    rst_n = 1'b1;
    read_all("R11");

    summary();
  end

endmodule